// File: doc/BRIEF.md
# Double-Buffer Transmit Credit Controller

This block is the host-side flow-control engine that feeds packets into a device with two fixed transmit buffers. It keeps a local write count of packets handed to the device. The device reports back a read count in the low bits of a status word. A new packet is granted only while fewer than two buffers are occupied. Occupancy is the write count minus the read count, taken modulo 16, so either counter may wrap.

Each granted packet is steered to the buffer picked by the low bit of the write count, so the two buffers alternate. At grant the block latches a small descriptor that precedes the payload: the packet length rounded up to a multiple of 4 bytes, and a control byte. The control byte carries a completion-report request in bit 7. An external copy engine is then asked to move the packet. When that engine reports completion, the write count steps by one and a one-cycle doorbell pulse is sent to the device.

The packet side is a valid/ready stream. `pkt_valid` may be raised at any time and the request fields must stay stable until `pkt_ready` is seen high. A packet transfers on the clock edge where both are high. `pkt_ready` stays low while a buffer credit is missing or a packet is still in flight, and that is the only back-pressure. The status word, the copy request/done pair, the buffer select and the doorbell are plain control pins.

Top module: `tx_credit_ctrl`

## Requirements
- R1: After reset `wr_count` is 0, and `doorbell` and `cp_req` are low.
- R2: In the idle state `pkt_ready` is high exactly when (`wr_count` − `dev_status[3:0]`) mod 16 is less than 2. Bits 7:4 of `dev_status` have no effect.
- R3: While the difference is 2 or more, a waiting packet is held off and `cp_req` stays low. The status is re-read every cycle, and the packet is granted on the first edge after the difference drops below 2.
- R4: Only one packet is in flight at a time. From the grant edge until the doorbell cycle has ended, `pkt_ready` is low whatever the status says.
- R5: During the copy, `buf_sel` equals bit 0 of `wr_count` as it was at the grant, so consecutive packets alternate between buffers 0 and 1.
- R6: During the copy, `desc_len` (17 bits) equals `pkt_len` at the grant rounded up to the next multiple of 4. Changes on `pkt_len` after the grant have no effect.
- R7: During the copy, `desc_ctrl` bit 7 equals `pkt_report` at the grant, and all other bits of `desc_ctrl` are 0.
- R8: A `cp_done` pulse during the copy makes `wr_count` step by one, wrapping from 15 to 0. On the next cycle `doorbell` is high for exactly that one cycle.
- R9: A `cp_done` pulse while no copy is pending has no effect on `wr_count` or `doorbell`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet request valid |
| pkt_ready | output | 1 | Packet grant (credit available and idle) |
| pkt_len | input | 16 | Packet length in bytes, including headers |
| pkt_report | input | 1 | Request a completion report for this packet |
| dev_status | input | 8 | Device status word; bits 3:0 carry the device read count |
| cp_req | output | 1 | Copy request to the copy engine, high until done |
| cp_done | input | 1 | One-cycle pulse: copy engine finished |
| buf_sel | output | 1 | Target buffer index for the current copy |
| desc_len | output | 17 | Descriptor length, rounded up to a multiple of 4 |
| desc_ctrl | output | 8 | Descriptor control byte; bit 7 requests a completion report |
| doorbell | output | 1 | One-cycle interrupt pulse toward the device |
| wr_count | output | 4 | Local write count |

## Verification
The assertions watch, on every cycle, that a grant never happens without a free credit, and that the doorbell never lasts two cycles. They also check that the write count only ever moves by one, and only together with a doorbell, and that the buffer select during a copy matches the write-count bit and that descriptor lengths are aligned. Other behaviours can only be shown by the bench scenarios. These are the admission decision across every pair of write and read counts, including wraparound, the grant arriving on the first cycle after a hold-off clears, and the descriptor contents for many lengths. The bench also shows that stray copy-done pulses and late length changes leave the outputs untouched.

// File: rtl/tx_credit_pkg.sv
package tx_credit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_RING = 2'd2
  } seq_state_t;

  localparam int CTRL_W     = 8;
  localparam int REPORT_BIT = 7;
endpackage

// File: rtl/tx_credit_gate.sv
module tx_credit_gate #(
  parameter int CNT_W   = 4,
  parameter int NUM_BUF = 2
) (
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] rd_cnt,
  output logic             room
);
  logic [CNT_W-1:0] occ;

  // modulo 2^CNT_W difference: wrap of either counter is harmless
  assign occ  = wr_cnt - rd_cnt;
  assign room = occ < CNT_W'(NUM_BUF);
endmodule

// File: rtl/tx_desc_pack.sv
module tx_desc_pack
  import tx_credit_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int ALIGN = 4
) (
  input  logic [LEN_W-1:0]  len,
  input  logic              report,
  output logic [LEN_W:0]    len_up,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int OUT_W    = LEN_W + 1;
  localparam int ALIGN_LG = $clog2(ALIGN);

  logic [OUT_W-1:0] sum;

  assign sum    = {1'b0, len} + OUT_W'(ALIGN - 1);
  assign len_up = sum & ~OUT_W'(ALIGN - 1);

  always_comb begin
    ctrl             = '0;
    ctrl[REPORT_BIT] = report;
  end

  always_comb begin
    if (!$isunknown(len)) begin
      AST_DESC_ALIGNED: assert (len_up[ALIGN_LG-1:0] == '0 && len_up >= {1'b0, len}) else $error("unaligned descriptor length"); // R6
    end
  end
endmodule

// File: rtl/tx_wr_counter.sv
module tx_wr_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tx_credit_ctrl.sv
module tx_credit_ctrl
  import tx_credit_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int NUM_BUF = 2,
  parameter int LEN_W   = 16,
  parameter int ALIGN   = 4,
  parameter int STAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              pkt_report,
  input  logic [STAT_W-1:0] dev_status,
  output logic              cp_req,
  input  logic              cp_done,
  output logic              buf_sel,
  output logic [LEN_W:0]    desc_len,
  output logic [CTRL_W-1:0] desc_ctrl,
  output logic              doorbell,
  output logic [CNT_W-1:0]  wr_count
);
  localparam int BSEL_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1;

  seq_state_t        state;
  logic              room;
  logic              accept;
  logic              inc;
  logic [BSEL_W-1:0] buf_q;
  logic [LEN_W:0]    len_up;
  logic [LEN_W:0]    len_q;
  logic [CTRL_W-1:0] ctrl_c;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  rd_cnt;

  assign rd_cnt = dev_status[CNT_W-1:0];

  tx_credit_gate #(.CNT_W(CNT_W), .NUM_BUF(NUM_BUF)) u_gate (
    .wr_cnt (wr_count),
    .rd_cnt (rd_cnt),
    .room   (room)
  );

  tx_desc_pack #(.LEN_W(LEN_W), .ALIGN(ALIGN)) u_desc (
    .len    (pkt_len),
    .report (pkt_report),
    .len_up (len_up),
    .ctrl   (ctrl_c)
  );

  tx_wr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (inc),
    .cnt   (wr_count)
  );

  assign pkt_ready = (state == ST_IDLE) && room;
  assign accept    = pkt_valid && pkt_ready;
  assign inc       = (state == ST_COPY) && cp_done;
  assign cp_req    = (state == ST_COPY);
  assign doorbell  = (state == ST_RING);
  assign buf_sel   = buf_q[0];
  assign desc_len  = len_q;
  assign desc_ctrl = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      buf_q  <= '0;
      len_q  <= '0;
      ctrl_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_COPY;
          buf_q  <= wr_count[BSEL_W-1:0];
          len_q  <= len_up;
          ctrl_q <= ctrl_c;
        end
        ST_COPY: if (cp_done) state <= ST_RING;
        ST_RING: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_GRANT_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n) (pkt_valid && pkt_ready) |-> (CNT_W'(wr_count - rd_cnt) < CNT_W'(NUM_BUF))); // R2
  AST_COPY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $rose(cp_req) |-> $past(pkt_valid && pkt_ready)); // R4
  AST_BUF_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n) cp_req |-> (buf_sel == wr_count[0])); // R5
  AST_DOORBELL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) doorbell |=> !doorbell); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (wr_count != $past(wr_count)) |-> (doorbell && wr_count == CNT_W'($past(wr_count) + 1'b1))); // R8
endmodule

// File: tb/tx_credit_ctrl_bench.sv
module tx_credit_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_valid;
  logic        pkt_ready;
  logic [15:0] pkt_len;
  logic        pkt_report;
  logic [7:0]  dev_status;
  logic        cp_req;
  logic        cp_done;
  logic        buf_sel;
  logic [16:0] desc_len;
  logic [7:0]  desc_ctrl;
  logic        doorbell;
  logic [3:0]  wr_count;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tx_credit_ctrl u_tx_credit_ctrl (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_len(pkt_len), .pkt_report(pkt_report), .dev_status(dev_status),
    .cp_req(cp_req), .cp_done(cp_done), .buf_sel(buf_sel), .desc_len(desc_len),
    .desc_ctrl(desc_ctrl), .doorbell(doorbell), .wr_count(wr_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_len = '0; pkt_report = 1'b0;
    dev_status = '0; cp_done = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step(); #1;
    chk("R1", "wr_count", int'(wr_count), 0);
    chk("R1", "doorbell", int'(doorbell), 0);
    chk("R1", "cp_req", int'(cp_req), 0);

    for (int p = 0; p < 36; p++) begin
      int w;
      int len;
      int exp_len;
      bit rep;
      w   = p % 16;
      len = (p == 35) ? 65535 : ((p * 97 + p % 4) % 2000);
      rep = p[0] ^ p[1];
      exp_len = ((len + 3) / 4) * 4;

      // R2: sweep every read count, upper status bits scrambled
      for (int r = 0; r < 16; r++) begin
        step();
        dev_status = 8'(((p * 7 + r * 3) % 16) * 16 + r);
        #1;
        chk("R2", "pkt_ready sweep", int'(pkt_ready), (((w - r) & 15) < 2) ? 1 : 0);
      end

      step();
      pkt_len = 16'(len); pkt_report = rep; pkt_valid = 1'b1;
      if (p % 4 == 1) begin
        dev_status = 8'((w - 2) & 15);
        for (int k = 0; k < 3; k++) begin
          #1;
          chk("R3", "held off ready", int'(pkt_ready), 0);
          step();
          chk("R3", "held off cp_req", int'(cp_req), 0);
        end
        dev_status = 8'((w - 1) & 15);
      end else begin
        dev_status = 8'((w - (p % 2)) & 15);
      end
      #1;
      chk("R3", "grant ready", int'(pkt_ready), 1);
      step();
      pkt_valid = 1'b0; pkt_len = 16'(len + 1); pkt_report = ~rep;
      dev_status = 8'(w);
      #1;
      chk("R4", "cp_req after grant", int'(cp_req), 1);
      chk("R4", "ready low in flight", int'(pkt_ready), 0);
      chk("R5", "buf_sel", int'(buf_sel), w & 1);
      chk("R6", "desc_len", int'(desc_len), exp_len);
      chk("R7", "desc_ctrl", int'(desc_ctrl), rep ? 128 : 0);
      for (int k = 0; k < p % 3; k++) begin
        step();
        chk("R8", "no doorbell while copying", int'(doorbell), 0);
        chk("R8", "count held while copying", int'(wr_count), w);
      end
      cp_done = 1'b1;
      step();
      cp_done = 1'b0;
      #1;
      chk("R8", "doorbell", int'(doorbell), 1);
      chk("R8", "wr_count step", int'(wr_count), (w + 1) & 15);
      chk("R4", "ready low at doorbell", int'(pkt_ready), 0);
      step();
      chk("R8", "doorbell single", int'(doorbell), 0);

      if (p % 5 == 0) begin
        cp_done = 1'b1;
        step();
        cp_done = 1'b0;
        #1;
        chk("R9", "stray done count", int'(wr_count), (w + 1) & 15);
        chk("R9", "stray done doorbell", int'(doorbell), 0);
        chk("R9", "stray done cp_req", int'(cp_req), 0);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule